// File: doc/BRIEF.md
# UART Command to Bus Bridge

This block lets a host on a serial line read and write single 32-bit words on an on-chip bus. The host sends bytes on `rxd`. Each byte uses 8 data bits, least significant bit first, no parity and one stop bit. The bridge collects a command byte and a big-endian word address. For a write it also collects four big-endian data bytes. It then runs one transfer on a request/acknowledge master port. For a read, it sends the captured word back on `txd` as four bytes, most significant byte first.

A host normally opens a session with the sync character 0x55. The bridge drops any byte that arrives while idle and does not have bit 7 set. The command byte is decoded as follows:
- Bit 7 marks the byte as a command.
- Bit 6 selects a write (1) or a read (0).
- Bits 5:0 hold the word count minus one. Only a value of zero is accepted.

So 0xC0 starts a write and 0x80 starts a read.

One bit lasts `16*TICK_DIV` clock cycles. The receiver oversamples each bit 16 times and takes its value at mid-bit.

The command parser has six states:
- `P_IDLE` waits for a command byte.
- `P_ADDR` collects the four address bytes.
- `P_DATA` collects the four write-data bytes.
- `P_BUS` holds the bus request.
- `P_SEND` starts one transmitted byte.
- `P_TXWAIT` waits for that byte to finish.

The transitions are:

| From | Condition | To |
|---|---|---|
| `P_IDLE` | valid command byte | `P_ADDR` |
| `P_ADDR` | fourth address byte, write command | `P_DATA` |
| `P_ADDR` | fourth address byte, read command | `P_BUS` |
| `P_DATA` | fourth data byte | `P_BUS` |
| `P_BUS` | acknowledge on a write | `P_IDLE` |
| `P_BUS` | acknowledge on a read | `P_SEND` |
| `P_SEND` | always, one cycle later | `P_TXWAIT` |
| `P_TXWAIT` | transmitter free, more bytes to send | `P_SEND` |
| `P_TXWAIT` | transmitter free, fourth byte sent | `P_IDLE` |
| `P_ADDR` or `P_DATA` | framing error | `P_IDLE` |

Top module: `uart_bus_bridge`

## Requirements
- R1: After reset, `bus_req` is 0, `txd` is 1 and `frame_err` is 0.
- R2: A byte received in idle with bit 7 clear is discarded. This covers the sync byte 0x55. It causes no bus transfer and no output on `txd`.
- R3: Command 0xC0 is followed by four address bytes and then four data bytes, each group most significant byte first. Exactly one bus write (`bus_we`=1) is issued, and only after the last data byte arrives.
- R4: Bits 1:0 of `bus_addr` are always driven as zero, whatever the last address byte holds.
- R5: Command 0x80 is followed by four address bytes, most significant byte first. One bus read (`bus_we`=0) is issued after the fourth address byte. The word read is then sent on `txd` as four 8N1 bytes, most significant byte first, each bit lasting `16*TICK_DIV` cycles.
- R6: `bus_req` stays high until the cycle in which `bus_ack` is high, and drops in the cycle after. While the request waits, `bus_addr`, `bus_wdata` and `bus_we` hold steady.
- R7: Read data is taken from `bus_rdata` in the acknowledge cycle. Later changes on `bus_rdata` do not affect the bytes returned.
- R8: A command byte with bit 7 set and a nonzero count field in bits 5:0 (for example 0xC1) is ignored. No transfer occurs, and the next byte is parsed as a fresh command.
- R9: A byte whose stop bit is sampled low produces a `frame_err` pulse exactly one cycle wide and is not delivered as data. If it arrives during a command, the parser abandons that command and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input from the host, idle high |
| txd | output | 1 | Serial output to the host, idle high |
| frame_err | output | 1 | One-cycle pulse when a received stop bit is low |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Word address, bits 1:0 always zero |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled in the acknowledge cycle |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
The receiver samples the stop bit 9.5 bit times after a start edge. `bus_req` rises two cycles later, so a transfer is due within a few cycles of the middle of the last stop bit. The bench reads the transfer counters only after its byte task has held the stop bit for a full bit and added one idle bit. The bus model raises `bus_ack` after a chosen number of cycles. It compares address, data and direction on every waiting cycle, and it drives `bus_rdata` with a garbage value once the acknowledge cycle has passed. For reads, the returned bytes start within one oversample tick of the acknowledge. The bench therefore decodes `txd` in parallel with sending the command: it syncs on each falling start edge and samples at mid-bit using the expected bit length.

// File: rtl/ubb_pkg.sv
package ubb_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int OVERSAMPLE = 16;
    localparam int CMD_FLAG   = 7;
    localparam int CMD_WRITE  = 6;
    localparam int CNT_W      = 6;

    typedef enum logic [2:0] {
        P_IDLE, P_ADDR, P_DATA, P_BUS, P_SEND, P_TXWAIT
    } parse_state_t;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_t;
endpackage

// File: rtl/ubb_baud_tick.sv
module ubb_baud_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = $clog2(TICK_DIV + 1);
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= (div_q == LAST);
            if (div_q == LAST) div_q <= '0;
            else               div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ubb_rx.sv
module ubb_rx
    import ubb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_ferr
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [TW-1:0] T_MID  = TW'(OVERSAMPLE / 2 - 1);
    localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

    rx_state_t   state_q;
    logic [2:0]  sync_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bcnt_q;
    logic          line, line_prev;

    assign line      = sync_q[1];
    assign line_prev = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RX_IDLE;
            sync_q   <= '1;
            tcnt_q   <= '0;
            bcnt_q   <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            sync_q   <= {sync_q[1:0], rxd};
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (line_prev && !line) begin
                        state_q <= RX_START;
                        tcnt_q  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt_q == T_MID) begin
                            tcnt_q  <= '0;
                            bcnt_q  <= '0;
                            state_q <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_LAST) begin
                            rx_byte <= {line, rx_byte[BYTE_W-1:1]};
                            if (bcnt_q == B_LAST) state_q <= RX_STOP;
                            else                  bcnt_q  <= bcnt_q + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_LAST) begin
                            rx_valid <= line;
                            rx_ferr  <= !line;
                            state_q  <= RX_IDLE;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    // R9
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |=> !rx_ferr);
    // R9
    rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ferr && rx_valid));
endmodule

// File: rtl/ubb_tx.sv
module ubb_tx
    import ubb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_start,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_busy,
    output logic              txd
);
    localparam int TW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [TW-1:0] T_LAST = TW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] B_LAST = BW'(BYTE_W - 1);

    tx_state_t     state_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bcnt_q;
    logic [BYTE_W-1:0] sh_q;

    assign tx_busy = (state_q != TX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            sh_q    <= '0;
            txd     <= 1'b1;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (tx_start) begin
                        sh_q    <= tx_data;
                        txd     <= 1'b0;
                        tcnt_q  <= '0;
                        state_q <= TX_START;
                    end
                end
                TX_START: begin
                    if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_LAST) begin
                            txd     <= sh_q[0];
                            sh_q    <= sh_q >> 1;
                            bcnt_q  <= '0;
                            state_q <= TX_DATA;
                        end
                    end
                end
                TX_DATA: begin
                    if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_LAST) begin
                            if (bcnt_q == B_LAST) begin
                                txd     <= 1'b1;
                                state_q <= TX_STOP;
                            end else begin
                                txd    <= sh_q[0];
                                sh_q   <= sh_q >> 1;
                                bcnt_q <= bcnt_q + 1'b1;
                            end
                        end
                    end
                end
                TX_STOP: begin
                    if (tick) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_LAST) state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // R5
    tx_start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && tx_start) |=> (!txd && tx_busy));
endmodule

// File: rtl/ubb_cmd_fsm.sv
module ubb_cmd_fsm
    import ubb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_ferr,
    input  logic              tx_busy,
    output logic              tx_start,
    output logic [BYTE_W-1:0] tx_data,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    localparam int CW = $clog2(WORD_BYTES);
    localparam logic [CW-1:0] C_LAST = CW'(WORD_BYTES - 1);

    parse_state_t      state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic              we_q;
    logic [WORD_W-1:0] addr_q, data_q, rd_q;
    logic              cmd_ok, cnt_last;

    assign cmd_ok   = rx_byte[CMD_FLAG] && (rx_byte[CNT_W-1:0] == '0);
    assign cnt_last = (cnt_q == C_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tx_start = 1'b0;
        unique case (state_q)
            P_IDLE:   if (rx_valid && cmd_ok) state_d = P_ADDR;
            P_ADDR: begin
                if (rx_ferr)                     state_d = P_IDLE;
                else if (rx_valid && cnt_last)   state_d = we_q ? P_DATA : P_BUS;
            end
            P_DATA: begin
                if (rx_ferr)                     state_d = P_IDLE;
                else if (rx_valid && cnt_last)   state_d = P_BUS;
            end
            P_BUS:    if (bus_ack) state_d = we_q ? P_IDLE : P_SEND;
            P_SEND: begin
                tx_start = 1'b1;
                state_d  = P_TXWAIT;
            end
            P_TXWAIT: if (!tx_busy) state_d = cnt_last ? P_IDLE : P_SEND;
            default:  state_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            we_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rd_q   <= '0;
        end else begin
            unique case (state_q)
                P_IDLE: if (rx_valid && cmd_ok) begin
                    we_q  <= rx_byte[CMD_WRITE];
                    cnt_q <= '0;
                end
                P_ADDR: if (rx_valid) begin
                    addr_q <= {addr_q[WORD_W-BYTE_W-1:0], rx_byte};
                    cnt_q  <= cnt_q + 1'b1;
                end
                P_DATA: if (rx_valid) begin
                    data_q <= {data_q[WORD_W-BYTE_W-1:0], rx_byte};
                    cnt_q  <= cnt_q + 1'b1;
                end
                P_BUS: if (bus_ack) begin
                    rd_q  <= bus_rdata;
                    cnt_q <= '0;
                end
                P_TXWAIT: if (!tx_busy) begin
                    rd_q  <= {rd_q[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign tx_data   = rd_q[WORD_W-1 -: BYTE_W];
    assign bus_req   = (state_q == P_BUS);
    assign bus_we    = we_q;
    assign bus_addr  = {addr_q[WORD_W-1:2], 2'b00};
    assign bus_wdata = data_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_req);
    // R6
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));
    // R6
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);
    // R2
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_IDLE && rx_valid && !rx_byte[CMD_FLAG]) |=> (state_q == P_IDLE));
endmodule

// File: rtl/uart_bus_bridge.sv
module uart_bus_bridge
    import ubb_pkg::*;
#(
    parameter int TICK_DIV = 27
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rxd,
    output logic        txd,
    output logic        frame_err,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata,
    input  logic        bus_ack
);
    logic              tick;
    logic [BYTE_W-1:0] rx_byte, tx_data;
    logic              rx_valid, tx_start, tx_busy;

    ubb_baud_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    ubb_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ferr(frame_err)
    );

    ubb_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .tx_start(tx_start),
        .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd)
    );

    ubb_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_ferr(frame_err), .tx_busy(tx_busy), .tx_start(tx_start),
        .tx_data(tx_data), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00));
endmodule

// File: tb/tb_uart_bus_bridge.sv
`timescale 1ns/1ps
module tb_uart_bus_bridge;
    localparam int TICK_DIV = 4;
    localparam int BIT      = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        txd, frame_err, bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    int checks = 0;
    int errors = 0;
    int ack_lat = 2;
    logic [31:0] rd_val = 32'h0;
    int txn_cnt = 0, stab_err = 0, ferr_cnt = 0, ferr_wide = 0, tx_low = 0;
    logic        last_we;
    logic [31:0] last_addr, last_wdata;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    uart_bus_bridge #(.TICK_DIV(TICK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .frame_err(frame_err),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bus responder
    initial begin
        bus_ack = 1'b0;
        bus_rdata = 32'h0;
        forever begin
            @(negedge clk);
            if (bus_req) begin
                logic [31:0] a, w;
                logic        e;
                a = bus_addr; w = bus_wdata; e = bus_we;
                for (int k = 0; k < ack_lat; k++) begin
                    @(negedge clk);
                    if (!bus_req || bus_addr != a || bus_wdata != w || bus_we != e) stab_err++;
                end
                bus_rdata = rd_val;
                bus_ack   = 1'b1;
                @(negedge clk);
                bus_ack   = 1'b0;
                bus_rdata = 32'hBAD0_BAD0;
                last_we = e; last_addr = a; last_wdata = w;
                txn_cnt++;
            end
        end
    end

    // pulse monitors
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (frame_err) ferr_cnt++;
                if (frame_err && prev) ferr_wide++;
                if (!txd) tx_low++;
                prev = frame_err;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = good_stop;
        repeat (BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8], 1'b1);
    endtask

    task automatic recv_byte(output logic [7:0] b, input string req);
        while (txd) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        chk(txd == 1'b0, req, {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        chk(txd == 1'b1, req, {31'h0, txd}, 32'h1);
    endtask

    task automatic recv_word(output logic [31:0] w, input string req);
        logic [7:0] b;
        for (int i = 3; i >= 0; i--) begin
            recv_byte(b, req);
            w[8*i +: 8] = b;
        end
    endtask

    task automatic t_reset();
        // R1
        chk(bus_req == 1'b0, "R1", {31'h0, bus_req}, 32'h0);
        chk(txd == 1'b1, "R1", {31'h0, txd}, 32'h1);
        chk(frame_err == 1'b0, "R1", {31'h0, frame_err}, 32'h0);
    endtask

    task automatic t_sync();
        int n0, t0;
        n0 = txn_cnt; t0 = tx_low;
        send_byte(8'h55, 1'b1);
        send_byte(8'h3A, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        // R2
        chk(txn_cnt == n0, "R2", txn_cnt, n0);
        chk(tx_low == t0, "R2", tx_low, t0);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
        int n0;
        n0 = txn_cnt;
        send_byte(8'hC0, 1'b1);
        send_word(a);
        for (int i = 3; i >= 1; i--) send_byte(d[8*i +: 8], 1'b1);
        chk(txn_cnt == n0, req, txn_cnt, n0);
        send_byte(d[7:0], 1'b1);
        chk(txn_cnt == n0 + 1, req, txn_cnt, n0 + 1);
        chk(last_we == 1'b1, req, {31'h0, last_we}, 32'h1);
        chk(last_addr == {a[31:2], 2'b00}, req, last_addr, {a[31:2], 2'b00});
        chk(last_wdata == d, req, last_wdata, d);
    endtask

    task automatic t_write();
        ack_lat = 3;
        do_write(32'h1234_5678, 32'hA5C3_0F96, "R3");
        ack_lat = 0;
        do_write(32'h0000_0100, 32'h0102_0304, "R3");
        chk(stab_err == 0, "R6", stab_err, 0);
    endtask

    task automatic t_unaligned();
        ack_lat = 1;
        // R4
        do_write(32'hCAFE_0007, 32'h5555_AAAA, "R4");
    endtask

    task automatic do_read(input logic [31:0] a, input logic [31:0] v, input int lat);
        logic [31:0] got;
        int n0;
        n0 = txn_cnt;
        ack_lat = lat;
        rd_val = v;
        fork
            begin
                send_byte(8'h80, 1'b1);
                send_word(a);
            end
            recv_word(got, "R5");
        join
        chk(txn_cnt == n0 + 1, "R5", txn_cnt, n0 + 1);
        chk(last_we == 1'b0, "R5", {31'h0, last_we}, 32'h0);
        chk(last_addr == {a[31:2], 2'b00}, "R5", last_addr, {a[31:2], 2'b00});
        // R7: bus_rdata is garbage after the ack cycle
        chk(got == v, "R7", got, v);
    endtask

    task automatic t_read();
        do_read(32'h8000_0010, 32'hDEAD_BEEF, 4);
        do_read(32'h0000_0FFC, 32'h0011_2233, 0);
        chk(stab_err == 0, "R6", stab_err, 0);
    endtask

    task automatic t_bad_count();
        int n0;
        n0 = txn_cnt;
        send_byte(8'hC1, 1'b1);
        send_byte(8'h41, 1'b1);
        repeat (BIT) @(negedge clk);
        // R8
        chk(txn_cnt == n0, "R8", txn_cnt, n0);
        ack_lat = 1;
        do_write(32'h0BAD_C0DC, 32'h7777_0001, "R8");
    endtask

    task automatic t_frame_err();
        int n0, f0;
        n0 = txn_cnt; f0 = ferr_cnt;
        send_byte(8'hC0, 1'b1);
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b0);
        // R9
        chk(ferr_cnt == f0 + 1, "R9", ferr_cnt, f0 + 1);
        chk(ferr_wide == 0, "R9", ferr_wide, 0);
        do_write(32'h4433_2210, 32'hFEED_F00D, "R9");
        chk(txn_cnt == n0 + 1, "R9", txn_cnt, n0 + 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_sync();
        t_write();
        t_unaligned();
        t_read();
        t_bad_count();
        t_frame_err();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule